// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block sorts one recorded control transfer into a category. Its inputs are the leading opcode bytes fetched at the source address, the ModRM byte, a flag that says the immediate displacement is zero, the privilege level of the source and target addresses, whether each address is nonzero, and the abort and in-transaction flags of the record. It produces a category word with exactly one kind bit set. That word also carries one bit for the privilege of the target and, when the request asks for it, one transaction-state bit.

The category is then tested against a request mask supplied by the branch-record filter. A record is kept only if its category is not empty and every bit of it appears in the request. A request that names every kind and both privilege levels keeps all records, including those that cannot be classified. Instruction-length decoding and fetching the bytes from memory are done upstream.

Classification and filtering are combinational. A generate-selected register stage (parameter `OUT_REG`, default 1) can sit on the result; with it the result appears one clock after the input.

Top module: `brcls_top`

## Requirements
- R1: With `op_cnt` >= 2 and `op0` = 0x0F, `op1` of 0x05 or 0x34 yields system call (bit 4), 0x07 or 0x35 yields system-call return (bit 5), and 0x80..0x8F yields conditional (bit 8).
- R2: Single-byte opcodes 0x70..0x7F and 0xE0..0xE3 yield conditional (bit 8).
- R3: 0xC2, 0xC3, 0xCA and 0xCB yield return (bit 3). 0xCF yields interrupt return (bit 7). 0xCC..0xCE yield software interrupt (bit 6). 0xE9..0xEB yield jump (bit 9). 0x9A yields call (bit 2).
- R4: 0xE8 yields call (bit 2) when `imm_zero` is 0 and zero-length call (bit 15) when `imm_zero` is 1.
- R5: 0xFF with `modrm[5:3]` equal to 2 or 3 yields indirect call (bit 11), with 4 or 5 yields indirect jump (bit 16), and with any other value yields no kind.
- R6: A transfer from a user source (`src_kern`=0) to a kernel target (`dst_kern`=1) whose kind is neither system call nor software interrupt becomes hardware interrupt/trap/fault (bit 10). This includes opcodes that are not recognised.
- R7: If either address is zero (`src_nz`=0 or `dst_nz`=0), the category is 0. Otherwise, if `abort` is 1, the category is abort (bit 12) plus the target privilege bit, whatever the opcode.
- R8: Every nonzero category carries exactly one target privilege bit: bit 0 for a user target and bit 1 for a kernel target.
- R9: If the request has bit 13 or bit 14 set, a nonzero category gains bit 13 when `in_tx`=1 and bit 14 when `in_tx`=0. Otherwise neither bit is set.
- R10: `out_keep` is 1 if the request contains all of bits 0..12, 15 and 16 (mask 0x19FFF). Otherwise it is 1 only when the category is nonzero and every category bit is also set in the request.
- R11: The category is 0 when the opcode bytes are unusable: `op_cnt`=0, `op0`=0x0F with `op_cnt` < 2, or `op0`=0xFF with `modrm_vld`=0.
- R12: With `OUT_REG`=1, `out_vld`, `out_cat` and `out_keep` reflect the inputs presented at the previous rising clock edge, and `out_vld` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A record is presented this cycle |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte |
| op_cnt | input | 2 | Number of usable opcode bytes (0..2) |
| modrm | input | 8 | ModRM byte |
| modrm_vld | input | 1 | ModRM byte is usable |
| imm_zero | input | 1 | Immediate displacement is zero |
| src_kern | input | 1 | Source address is in kernel space |
| dst_kern | input | 1 | Target address is in kernel space |
| src_nz | input | 1 | Source address is nonzero |
| dst_nz | input | 1 | Target address is nonzero |
| abort | input | 1 | Record is a transaction abort |
| in_tx | input | 1 | Record lies inside a transaction |
| req_mask | input | 17 | Requested category bits |
| out_vld | output | 1 | Result valid |
| out_cat | output | 17 | Category word |
| out_keep | output | 1 | Keep (1) or discard (0) the record |

## Verification
The only state is the output register, so a fault there shows at the ports one cycle after the input that caused it. A wrong category or keep value shows on the record it belongs to, and a stuck valid bit shows as an unexpected or missing result. Faults in the decoder are combinational and appear only for the opcodes they affect. The stimulus therefore covers every opcode group, each ModRM extension case, the privilege-crossing reclassification and each input that makes a record unusable, and compares every result against an expected value.

// File: rtl/brcls_pkg.sv
package brcls_pkg;
  localparam int CAT_W  = 17;
  localparam int CNT_W  = 2;

  // category bit positions
  localparam int CB_USR   = 0;
  localparam int CB_KRN   = 1;
  localparam int CB_CALL  = 2;
  localparam int CB_RET   = 3;
  localparam int CB_SYSC  = 4;
  localparam int CB_SYSR  = 5;
  localparam int CB_SWI   = 6;
  localparam int CB_IRET  = 7;
  localparam int CB_COND  = 8;
  localparam int CB_JMP   = 9;
  localparam int CB_HWI   = 10;
  localparam int CB_ICALL = 11;
  localparam int CB_ABT   = 12;
  localparam int CB_INTX  = 13;
  localparam int CB_NOTX  = 14;
  localparam int CB_ZCALL = 15;
  localparam int CB_IJMP  = 16;

  localparam logic [CAT_W-1:0] TX_MASK   = (CAT_W'(1) << CB_INTX) | (CAT_W'(1) << CB_NOTX);
  localparam logic [CAT_W-1:0] PRIV_MASK = (CAT_W'(1) << CB_USR) | (CAT_W'(1) << CB_KRN);
  localparam logic [CAT_W-1:0] ALL_MASK  = {CAT_W{1'b1}} & ~TX_MASK;
  localparam logic [CAT_W-1:0] KIND_MASK = ALL_MASK & ~PRIV_MASK;
endpackage

// File: rtl/brcls_decode.sv
module brcls_decode
  import brcls_pkg::*;
(
  input  logic [7:0]       op0,
  input  logic [7:0]       op1,
  input  logic [CNT_W-1:0] op_cnt,
  input  logic [7:0]       modrm,
  input  logic             modrm_vld,
  input  logic             imm_zero,
  output logic [CAT_W-1:0] kind,
  output logic             bytes_ok
);
  always_comb begin
    kind     = '0;
    bytes_ok = (op_cnt != '0);
    if (op_cnt != '0) begin
      case (op0) inside
        8'h0F: begin
          if (op_cnt < CNT_W'(2)) begin
            bytes_ok = 1'b0;
          end else begin
            case (op1) inside
              8'h05, 8'h34:  kind[CB_SYSC] = 1'b1;
              8'h07, 8'h35:  kind[CB_SYSR] = 1'b1;
              [8'h80:8'h8F]: kind[CB_COND] = 1'b1;
              default:       kind = '0;
            endcase
          end
        end
        [8'h70:8'h7F], [8'hE0:8'hE3]: kind[CB_COND] = 1'b1;
        8'hC2, 8'hC3, 8'hCA, 8'hCB:   kind[CB_RET]  = 1'b1;
        8'hCF:                        kind[CB_IRET] = 1'b1;
        [8'hCC:8'hCE]:                kind[CB_SWI]  = 1'b1;
        [8'hE9:8'hEB]:                kind[CB_JMP]  = 1'b1;
        8'h9A:                        kind[CB_CALL] = 1'b1;
        8'hE8: begin
          if (imm_zero) kind[CB_ZCALL] = 1'b1;
          else          kind[CB_CALL]  = 1'b1;
        end
        8'hFF: begin
          if (!modrm_vld) begin
            bytes_ok = 1'b0;
          end else begin
            case (modrm[5:3])
              3'd2, 3'd3: kind[CB_ICALL] = 1'b1;
              3'd4, 3'd5: kind[CB_IJMP]  = 1'b1;
              default:    kind = '0;
            endcase
          end
        end
        default: kind = '0;
      endcase
    end
  end
endmodule

// File: rtl/brcls_qualify.sv
module brcls_qualify
  import brcls_pkg::*;
(
  input  logic [CAT_W-1:0] kind,
  input  logic             bytes_ok,
  input  logic             src_kern,
  input  logic             dst_kern,
  input  logic             src_nz,
  input  logic             dst_nz,
  input  logic             abort,
  input  logic             in_tx,
  input  logic [CAT_W-1:0] req_mask,
  output logic [CAT_W-1:0] cat
);
  logic [CAT_W-1:0] priv;
  logic [CAT_W-1:0] base;
  logic             crossing;

  always_comb begin
    priv = '0;
    if (dst_kern) priv[CB_KRN] = 1'b1;
    else          priv[CB_USR] = 1'b1;

    crossing = !src_kern && dst_kern;
    base     = '0;
    if (!(src_nz && dst_nz)) begin
      base = '0;
    end else if (abort) begin
      base = priv;
      base[CB_ABT] = 1'b1;
    end else if (bytes_ok) begin
      base = kind;
      if (crossing && !kind[CB_SYSC] && !kind[CB_SWI]) begin
        base = '0;
        base[CB_HWI] = 1'b1;
      end
      if (base != '0) base = base | priv;
    end

    cat = base;
    if (base != '0 && (req_mask & TX_MASK) != '0) begin
      if (in_tx) cat[CB_INTX] = 1'b1;
      else       cat[CB_NOTX] = 1'b1;
    end
  end
endmodule

// File: rtl/brcls_filter.sv
module brcls_filter
  import brcls_pkg::*;
(
  input  logic [CAT_W-1:0] cat,
  input  logic [CAT_W-1:0] req_mask,
  output logic             keep
);
  logic want_all;
  logic covered;

  always_comb begin
    want_all = ((req_mask & ALL_MASK) == ALL_MASK);
    covered  = (cat != '0) && ((cat & ~req_mask) == '0);
    keep     = want_all || covered;
  end
endmodule

// File: rtl/brcls_top.sv
module brcls_top
  import brcls_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [7:0]       op0,
  input  logic [7:0]       op1,
  input  logic [CNT_W-1:0] op_cnt,
  input  logic [7:0]       modrm,
  input  logic             modrm_vld,
  input  logic             imm_zero,
  input  logic             src_kern,
  input  logic             dst_kern,
  input  logic             src_nz,
  input  logic             dst_nz,
  input  logic             abort,
  input  logic             in_tx,
  input  logic [CAT_W-1:0] req_mask,
  output logic             out_vld,
  output logic [CAT_W-1:0] out_cat,
  output logic             out_keep
);
  logic [CAT_W-1:0] kind;
  logic             bytes_ok;
  logic [CAT_W-1:0] cat_c;
  logic             keep_c;

  brcls_decode u_dec (
    .op0(op0), .op1(op1), .op_cnt(op_cnt), .modrm(modrm),
    .modrm_vld(modrm_vld), .imm_zero(imm_zero),
    .kind(kind), .bytes_ok(bytes_ok)
  );

  brcls_qualify u_qual (
    .kind(kind), .bytes_ok(bytes_ok), .src_kern(src_kern), .dst_kern(dst_kern),
    .src_nz(src_nz), .dst_nz(dst_nz), .abort(abort), .in_tx(in_tx),
    .req_mask(req_mask), .cat(cat_c)
  );

  brcls_filter u_filt (
    .cat(cat_c), .req_mask(req_mask), .keep(keep_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic             vld_q, vld_d;
      logic [CAT_W-1:0] cat_q, cat_d;
      logic             keep_q, keep_d;
      logic             data_en;

      always_comb begin
        data_en = in_vld;
        vld_d   = in_vld;
        cat_d   = cat_c;
        keep_d  = keep_c;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          cat_q  <= '0;
          keep_q <= 1'b0;
        end else begin
          vld_q <= vld_d;
          if (data_en) begin
            cat_q  <= cat_d;
            keep_q <= keep_d;
          end
        end
      end

      assign out_vld  = vld_q;
      assign out_cat  = cat_q;
      assign out_keep = keep_q;
    end else begin : g_comb
      assign out_vld  = in_vld;
      assign out_cat  = cat_c;
      assign out_keep = keep_c;
    end
  endgenerate
endmodule

// File: rtl/brcls_chk.sv
module brcls_chk
  import brcls_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             src_nz,
  input logic             dst_nz,
  input logic             abort,
  input logic             dst_kern,
  input logic [CAT_W-1:0] req_mask,
  input logic             out_vld,
  input logic [CAT_W-1:0] out_cat,
  input logic             out_keep
);
  logic             d_vld, d_snz, d_dnz, d_abt, d_dk;
  logic [CAT_W-1:0] d_req;

  generate
    if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_vld <= 1'b0; d_snz <= 1'b0; d_dnz <= 1'b0;
          d_abt <= 1'b0; d_dk  <= 1'b0; d_req <= '0;
        end else begin
          d_vld <= in_vld; d_snz <= src_nz; d_dnz <= dst_nz;
          d_abt <= abort;  d_dk  <= dst_kern; d_req <= req_mask;
        end
      end
    end else begin : g_now
      always_comb begin
        d_vld = in_vld; d_snz = src_nz; d_dnz = dst_nz;
        d_abt = abort;  d_dk  = dst_kern; d_req = req_mask;
      end
    end
  endgenerate

  // R1..R5: at most one kind bit
  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $countones(out_cat & KIND_MASK) <= 1);

  // R8: nonzero category carries exactly one privilege bit, matching target
  a_r8_priv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_cat != '0) |-> ($onehot(out_cat & PRIV_MASK) && out_cat[CB_KRN] == d_dk));

  // R9: transaction bits only when requested, never both
  a_r9_tx_bits: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($onehot0(out_cat & TX_MASK) &&
                 ((d_req & TX_MASK) != '0 || (out_cat & TX_MASK) == '0)));

  // R7: zero address gives empty category; abort gives abort bit
  a_r7_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !(d_snz && d_dnz)) |-> out_cat == '0);
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && d_snz && d_dnz && d_abt) |-> out_cat[CB_ABT]);

  // R10: a kept record under a partial request is fully covered
  a_r10_keep_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_keep && (d_req & ALL_MASK) != ALL_MASK) |->
      (out_cat != '0 && (out_cat & ~d_req) == '0));

  // R12: output valid follows input valid with the configured latency
  a_r12_vld_track: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == d_vld);
endmodule

bind brcls_top brcls_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_nz(src_nz), .dst_nz(dst_nz),
  .abort(abort), .dst_kern(dst_kern), .req_mask(req_mask),
  .out_vld(out_vld), .out_cat(out_cat), .out_keep(out_keep)
);

// File: tb/brcls_top_tb.sv
module brcls_top_tb;
  localparam int W = 17;
  localparam logic [W-1:0] U = 17'h00001, K = 17'h00002, CALL = 17'h00004,
    RET = 17'h00008, SYSC = 17'h00010, SYSR = 17'h00020, SWI = 17'h00040,
    IRET = 17'h00080, COND = 17'h00100, JMP = 17'h00200, HWI = 17'h00400,
    ICALL = 17'h00800, ABT = 17'h01000, INTX = 17'h02000, NOTX = 17'h04000,
    ZC = 17'h08000, IJMP = 17'h10000, ALLM = 17'h19FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld, modrm_vld, imm_zero, src_kern, dst_kern, src_nz, dst_nz, abort, in_tx;
  logic [7:0] op0, op1, modrm;
  logic [1:0] op_cnt;
  logic [W-1:0] req_mask;
  logic out_vld, out_keep;
  logic [W-1:0] out_cat;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] cat;
    logic         keep;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  brcls_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op0(op0), .op1(op1), .op_cnt(op_cnt),
    .modrm(modrm), .modrm_vld(modrm_vld), .imm_zero(imm_zero), .src_kern(src_kern),
    .dst_kern(dst_kern), .src_nz(src_nz), .dst_nz(dst_nz), .abort(abort), .in_tx(in_tx),
    .req_mask(req_mask), .out_vld(out_vld), .out_cat(out_cat), .out_keep(out_keep)
  );

  // driver: push expected item and present stimulus for one cycle
  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [1:0] cnt,
                      input logic [7:0] mr, input logic mv, input logic iz,
                      input logic sk, input logic dk, input logic snz, input logic dnz,
                      input logic ab, input logic tx, input logic [W-1:0] rq,
                      input logic [W-1:0] ecat, input logic ekeep, input string tag);
    exp_t e;
    @(negedge clk);
    e.cat = ecat; e.keep = ekeep; e.tag = tag;
    q.push_back(e);
    in_vld = 1'b1; op0 = b0; op1 = b1; op_cnt = cnt; modrm = mr; modrm_vld = mv;
    imm_zero = iz; src_kern = sk; dst_kern = dk; src_nz = snz; dst_nz = dnz;
    abort = ab; in_tx = tx; req_mask = rq;
  endtask

  // simple single-byte shorthand, user to user, all requested
  task automatic op1b(input logic [7:0] b0, input logic [W-1:0] ecat, input string tag);
    send(b0, 8'h00, 2'd1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
         ALLM, ecat, 1'b1, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected result: actual cat=%h keep=%0d expected no result",
                 out_cat, out_keep);
      end else begin
        e = q.pop_front();
        if (out_cat !== e.cat || out_keep !== e.keep) begin
          errors++;
          $display("FAIL %s: actual cat=%h keep=%0d expected cat=%h keep=%0d",
                   e.tag, out_cat, out_keep, e.cat, e.keep);
        end
      end
    end
  end

  task automatic idle_check(input string tag);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual vld=%0d pending=%0d expected vld=0 pending=0",
               tag, out_vld, q.size());
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; op0 = '0; op1 = '0; op_cnt = '0; modrm = '0;
    modrm_vld = 1'b0; imm_zero = 1'b0; src_kern = 1'b0; dst_kern = 1'b0;
    src_nz = 1'b0; dst_nz = 1'b0; abort = 1'b0; in_tx = 1'b0; req_mask = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_cat !== '0 || out_keep !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual vld=%0d cat=%h keep=%0d expected 0/0/0",
               out_vld, out_cat, out_keep);
    end
    rst_n = 1'b1;

    // R1
    send(8'h0F, 8'h05, 2'd2, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, SYSC|U, 1, "R1 0f05");
    send(8'h0F, 8'h34, 2'd2, 0, 1, 0, 0, 1, 1, 1, 0, 0, ALLM, SYSC|K, 1, "R1 0f34 to kernel");
    send(8'h0F, 8'h35, 2'd2, 0, 1, 0, 1, 0, 1, 1, 0, 0, ALLM, SYSR|U, 1, "R1 0f35");
    send(8'h0F, 8'h07, 2'd2, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, SYSR|U, 1, "R1 0f07");
    send(8'h0F, 8'h84, 2'd2, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, COND|U, 1, "R1 0f84");
    send(8'h0F, 8'h8F, 2'd2, 0, 1, 0, 1, 1, 1, 1, 0, 0, ALLM, COND|K, 1, "R1 0f8f kernel");
    send(8'h0F, 8'h90, 2'd2, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, 17'h0, 1, "R1 0f90 none");
    // R2
    op1b(8'h70, COND|U, "R2 70");
    op1b(8'h7F, COND|U, "R2 7f");
    op1b(8'hE0, COND|U, "R2 e0");
    op1b(8'hE3, COND|U, "R2 e3");
    op1b(8'hE4, 17'h0, "R2 e4 none");
    // R3
    op1b(8'hC2, RET|U, "R3 c2");
    op1b(8'hC3, RET|U, "R3 c3");
    op1b(8'hCA, RET|U, "R3 ca");
    op1b(8'hCB, RET|U, "R3 cb");
    op1b(8'hCF, IRET|U, "R3 cf");
    op1b(8'hCC, SWI|U, "R3 cc");
    op1b(8'hCE, SWI|U, "R3 ce");
    op1b(8'hE9, JMP|U, "R3 e9");
    op1b(8'hEB, JMP|U, "R3 eb");
    op1b(8'h9A, CALL|U, "R3 9a");
    // R4
    send(8'hE8, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, CALL|U, 1, "R4 e8 disp");
    send(8'hE8, 0, 2'd1, 0, 1, 1, 0, 0, 1, 1, 0, 0, ALLM, ZC|U, 1, "R4 e8 zero");
    // R5
    send(8'hFF, 0, 2'd1, 8'h10, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, ICALL|U, 1, "R5 ext2");
    send(8'hFF, 0, 2'd1, 8'hD8, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, ICALL|U, 1, "R5 ext3");
    send(8'hFF, 0, 2'd1, 8'h20, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, IJMP|U, 1, "R5 ext4");
    send(8'hFF, 0, 2'd1, 8'h2F, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, IJMP|U, 1, "R5 ext5");
    send(8'hFF, 0, 2'd1, 8'h30, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, 17'h0, 1, "R5 ext6 none");
    // R6
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 1, 1, 1, 0, 0, ALLM, HWI|K, 1, "R6 jcc u2k");
    send(8'hCD, 0, 2'd1, 0, 1, 0, 0, 1, 1, 1, 0, 0, ALLM, SWI|K, 1, "R6 int u2k");
    send(8'h0F, 8'h05, 2'd2, 0, 1, 0, 0, 1, 1, 1, 0, 0, ALLM, SYSC|K, 1, "R6 syscall u2k");
    send(8'h90, 0, 2'd1, 0, 1, 0, 0, 1, 1, 1, 0, 0, ALLM, HWI|K, 1, "R6 unknown u2k");
    send(8'h90, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, 17'h0, 1, "R6 unknown u2u");
    send(8'hC3, 0, 2'd1, 0, 1, 0, 1, 1, 1, 1, 0, 0, ALLM, RET|K, 1, "R6 k2k no reclass");
    // R7
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 0, 1, 0, 0, ALLM, 17'h0, 1, "R7 src zero");
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 1, 0, 1, 0, ALLM, 17'h0, 1, "R7 dst zero abort");
    send(8'h75, 0, 2'd1, 0, 1, 0, 1, 0, 1, 1, 1, 0, ALLM, ABT|U, 1, "R7 abort user");
    send(8'h90, 0, 2'd0, 0, 0, 0, 0, 1, 1, 1, 1, 0, ALLM, ABT|K, 1, "R7 abort no bytes");
    // R9
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, U|COND|NOTX, COND|U|NOTX, 1, "R9 notx");
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 1, U|COND|NOTX, COND|U|INTX, 0, "R9 intx drop");
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 1, U|COND|INTX, COND|U|INTX, 1, "R9 intx keep");
    send(8'h90, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 1, U|COND|INTX, 17'h0, 0, "R9 none no tx");
    // R10
    send(8'h75, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, U|RET, COND|U, 0, "R10 cond dropped");
    send(8'hC3, 0, 2'd1, 0, 1, 0, 1, 1, 1, 1, 0, 0, U|RET, RET|K, 0, "R10 kernel dropped");
    send(8'hC3, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, U|RET, RET|U, 1, "R10 ret kept");
    send(8'h90, 0, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, U|RET, 17'h0, 0, "R10 none dropped");
    send(8'h90, 0, 2'd1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 17'h1FFFF, 17'h0, 1, "R10 all keeps none");
    // R11
    send(8'h75, 0, 2'd0, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, 17'h0, 1, "R11 no bytes");
    send(8'h0F, 8'h05, 2'd1, 0, 1, 0, 0, 0, 1, 1, 0, 0, ALLM, 17'h0, 1, "R11 short 0f");
    send(8'hFF, 0, 2'd1, 8'h10, 0, 0, 0, 1, 1, 1, 0, 0, ALLM, 17'h0, 1, "R11 ff no modrm");
    // R12: gap then back-to-back
    idle_check("R12 idle after burst");
    op1b(8'hEA, JMP|U, "R12 after gap a");
    op1b(8'hCF, IRET|U, "R12 after gap b");
    idle_check("R12 idle final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule